// File: doc/BRIEF.md
# Mixed-Width Byte FIFO Data Port

This block is a 16-bit data register on a simple register bus. Behind it sits a byte-wide FIFO. Software uses it to write transmit data and to read receive data. Each access can be a word or a single byte, and the two sizes can be mixed in any order. The FIFO keeps one continuous byte stream whatever sizes are used.

Packing is big-endian. A word write stores bits 15:8 first and bits 7:0 second. A word read returns the oldest byte in bits 15:8 and the next byte in bits 7:0. The register sits at the even address. Any access with the address bit set is rejected, and so is a cycle that asserts write and read together. Such an access leaves the FIFO unchanged and sets a sticky access-error flag.

An access that does not fit is dropped. This covers a write that needs more free space than the FIFO has, and a read that asks for more bytes than it holds. A dropped access sets a sticky overflow or underflow flag. The flags are cleared by a dedicated clear input. The depth is a parameter, and the block reports its occupancy.

Top module: `byte_fifo_port`

## Requirements
- R1: A legal word write (`word_i`=1, `addr_i`=0) pushes `wdata_i[15:8]` first and then `wdata_i[7:0]`.
- R2: A legal byte write (`word_i`=0, `addr_i`=0) pushes `wdata_i[7:0]`. A byte read returns the popped byte on `rdata_o[7:0]`, with `rdata_o[15:8]` equal to zero.
- R3: A legal word read pops two bytes and returns the older one on `rdata_o[15:8]` and the newer one on `rdata_o[7:0]`. Read data appears in the cycle after the read strobe and holds until the next accepted read.
- R4: Byte and word accesses interleave freely. Writing word 0x0123, byte 0x45, word 0x6789 and byte 0xAB stores bytes 01,23,45,67,89,AB in that order. Reading byte, word, byte, word then returns 0x0001, 0x2345, 0x0067 and 0x89AB.
- R5: An access with `addr_i`=1, of either size, leaves the FIFO unchanged and sets `acc_err_o`. So does a cycle with `wr_i` and `rd_i` both high.
- R6: A word write needs two free bytes and a byte write needs one. A write that does not fit is dropped, leaving the FIFO unchanged, and sets `ovf_o`.
- R7: A word read needs two stored bytes and a byte read needs one. A read that cannot be served is dropped, leaving the FIFO unchanged, and sets `udf_o`.
- R8: `count_o` gives the number of stored bytes. `empty_o` is 1 when the count is 0. `full_o` is 1 when the count equals DEPTH.
- R9: `err_clr_i` clears `acc_err_o`, `ovf_o` and `udf_o` in the next cycle. If a new error occurs in the same cycle as the clear, that error's flag is set.
- R10: After reset the count is 0, `empty_o`=1, `full_o`=0, and all three error flags are 0.
- R11: The byte order stays correct when the storage pointers wrap around the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Byte address bit; 0 is the register base |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| word_i | input | 1 | 1 selects a word access, 0 a byte access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| err_clr_i | input | 1 | Clears the sticky error flags |
| empty_o | output | 1 | FIFO holds no bytes |
| full_o | output | 1 | FIFO holds DEPTH bytes |
| count_o | output | $clog2(DEPTH+1) | Stored byte count |
| ovf_o | output | 1 | Sticky flag: a write was dropped |
| udf_o | output | 1 | Sticky flag: a read was dropped |
| acc_err_o | output | 1 | Sticky flag: an illegal access was made |

## Verification
The main test writes a mix of word and byte accesses and reads them back with a different mix of sizes. This shows whether the packing order holds across size changes, and not only within words of one size. Filling the FIFO with words and then offering a word write at one free byte separates the one-byte and two-byte space checks. Draining down to one byte and then offering a word read does the same for the stored-byte checks. A long alternating write and read run moves the pointers past the end of the buffer, so a wrap error shows up as wrong byte order. Accesses at the odd address and cycles with both strobes high are followed by a read of the count, which shows that they left the FIFO alone.

// File: rtl/byte_fifo_port_pkg.sv
package byte_fifo_port_pkg;
  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_ONE  = 2'd1,
    XF_TWO  = 2'd2
  } xfer_e;
endpackage

// File: rtl/byte_fifo_store.sv
module byte_fifo_store
  import byte_fifo_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_e         push_n_i,
  input  logic [7:0]    push_b0_i,
  input  logic [7:0]    push_b1_i,
  input  xfer_e         pop_n_i,
  output logic [7:0]    head0_o,
  output logic [7:0]    head1_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_n_i != XF_NONE) mem_q[wptr_q] <= push_b0_i;
    if (push_n_i == XF_TWO)  mem_q[adv(wptr_q, 1)] <= push_b1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= adv(wptr_q, int'(push_n_i));
      rptr_q <= adv(rptr_q, int'(pop_n_i));
      cnt_q  <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign head0_o = mem_q[rptr_q];
  assign head1_o = mem_q[adv(rptr_q, 1)];
  assign count_o = cnt_q;
endmodule

// File: rtl/byte_fifo_access_ctrl.sv
module byte_fifo_access_ctrl
  import byte_fifo_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          word_i,
  input  logic [CW-1:0] count_i,
  output xfer_e         push_n_o,
  output xfer_e         pop_n_o,
  output logic          rd_ok_o,
  output logic          ovf_set_o,
  output logic          udf_set_o,
  output logic          acc_set_o
);
  logic          legal;
  logic [CW-1:0] free_b;
  logic [CW-1:0] need;

  assign legal  = !addr_i && !(wr_i && rd_i);
  assign free_b = CW'(DEPTH) - count_i;
  assign need   = word_i ? CW'(2) : CW'(1);

  always_comb begin
    push_n_o  = XF_NONE;
    pop_n_o   = XF_NONE;
    rd_ok_o   = 1'b0;
    ovf_set_o = 1'b0;
    udf_set_o = 1'b0;
    acc_set_o = (wr_i || rd_i) && !legal;
    if (legal && wr_i) begin
      if (free_b >= need) push_n_o = word_i ? XF_TWO : XF_ONE;
      else                ovf_set_o = 1'b1;
    end
    if (legal && rd_i) begin
      if (count_i >= need) begin
        pop_n_o = word_i ? XF_TWO : XF_ONE;
        rd_ok_o = 1'b1;
      end else begin
        udf_set_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_fifo_sticky.sv
module byte_fifo_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // new event beats clear
      else if (clr_i)    q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
  import byte_fifo_port_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          word_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  input  logic          err_clr_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          acc_err_o
);
  xfer_e         push_n, pop_n;
  logic          rd_ok, ovf_set, udf_set, acc_set;
  logic [7:0]    head0, head1;
  logic [CW-1:0] cnt;
  logic [2:0]    flags;
  logic [15:0]   rdata_q;

  byte_fifo_access_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .word_i   (word_i),
    .count_i  (cnt),
    .push_n_o (push_n),
    .pop_n_o  (pop_n),
    .rd_ok_o  (rd_ok),
    .ovf_set_o(ovf_set),
    .udf_set_o(udf_set),
    .acc_set_o(acc_set)
  );

  // word write: high byte enters first
  byte_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (push_n),
    .push_b0_i(word_i ? wdata_i[15:8] : wdata_i[7:0]),
    .push_b1_i(wdata_i[7:0]),
    .pop_n_i  (pop_n),
    .head0_o  (head0),
    .head1_o  (head1),
    .count_o  (cnt)
  );

  byte_fifo_sticky #(.N(3)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (err_clr_i),
    .set_i ({acc_set, udf_set, ovf_set}),
    .flag_o(flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_ok) rdata_q <= word_i ? {head0, head1} : {8'h00, head0};
  end

  assign rdata_o   = rdata_q;
  assign count_o   = cnt;
  assign empty_o   = (cnt == '0);
  assign full_o    = (cnt == CW'(DEPTH));
  assign ovf_o     = flags[0];
  assign udf_o     = flags[1];
  assign acc_err_o = flags[2];
endmodule

// File: rtl/byte_fifo_port_chk.sv
module byte_fifo_port_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          addr_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          word_i,
  input logic [15:0]   rdata_o,
  input logic          err_clr_i,
  input logic          empty_o,
  input logic          full_o,
  input logic [CW-1:0] count_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic          acc_err_o
);
  // R8
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH && !(empty_o && full_o));

  // R5
  illegal_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && addr_i) || (wr_i && rd_i) |=> acc_err_o && $stable(count_o));

  // R6
  write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i && !addr_i && (full_o || (word_i && int'(count_o) == DEPTH - 1))
    |=> ovf_o && $stable(count_o));

  // R7
  read_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && !addr_i && (empty_o || (word_i && int'(count_o) == 1))
    |=> udf_o && $stable(count_o) && $stable(rdata_o));

  // R2
  byte_read_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && !addr_i && !word_i && !empty_o |=> rdata_o[15:8] == 8'h00);

  // R1
  word_write_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !rd_i && !addr_i && word_i && int'(count_o) <= DEPTH - 2
    |=> int'(count_o) == int'($past(count_o)) + 2);

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i && !wr_i && !rd_i |=> !ovf_o && !udf_o && !acc_err_o);
endmodule

bind byte_fifo_port byte_fifo_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .word_i   (word_i),
  .rdata_o  (rdata_o),
  .err_clr_i(err_clr_i),
  .empty_o  (empty_o),
  .full_o   (full_o),
  .count_o  (count_o),
  .ovf_o    (ovf_o),
  .udf_o    (udf_o),
  .acc_err_o(acc_err_o)
);

// File: tb/tb_byte_fifo_port.sv
module tb_byte_fifo_port;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, word_i = 1'b0, err_clr_i = 1'b0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic          empty_o, full_o, ovf_o, udf_o, acc_err_o;
  logic [CW-1:0] count_o;

  int n_tests = 0;
  int n_fail = 0;
  byte unsigned model[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_fifo_port #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .word_i(word_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_clr_i(err_clr_i),
    .empty_o(empty_o), .full_o(full_o), .count_o(count_o), .ovf_o(ovf_o),
    .udf_o(udf_o), .acc_err_o(acc_err_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, sample at next negedge
  task automatic bus(input logic a, input logic w, input logic r, input logic wd,
                     input logic [15:0] d, input logic clr);
    addr_i = a; wr_i = w; rd_i = r; word_i = wd; wdata_i = d; err_clr_i = clr;
    @(negedge clk);
    addr_i = 0; wr_i = 0; rd_i = 0; word_i = 0; wdata_i = '0; err_clr_i = 0;
  endtask

  task automatic put(input logic wd, input logic [15:0] d);
    bus(1'b0, 1'b1, 1'b0, wd, d, 1'b0);
    if (wd) begin model.push_back(d[15:8]); model.push_back(d[7:0]); end
    else model.push_back(d[7:0]);
  endtask

  task automatic get(input string req, input logic wd);
    int exp;
    bus(1'b0, 1'b0, 1'b1, wd, 16'h0, 1'b0);
    if (wd) begin exp = int'(model[0]) << 8 | int'(model[1]); void'(model.pop_front()); end
    else exp = int'(model[0]);
    void'(model.pop_front());
    check(req, "read data", int'(rdata_o), exp);
  endtask

  task automatic clear_flags();
    bus(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic t_reset();
    check("R10", "count", int'(count_o), 0);
    check("R10", "empty", int'(empty_o), 1);
    check("R10", "full", int'(full_o), 0);
    check("R10", "flags", int'({ovf_o, udf_o, acc_err_o}), 0);
  endtask

  task automatic t_mixed();
    put(1'b1, 16'h0123); check("R1", "count after word", int'(count_o), 2);
    put(1'b0, 16'hFF45); check("R2", "count after byte", int'(count_o), 3);
    put(1'b1, 16'h6789);
    put(1'b0, 16'h00AB); check("R4", "count", int'(count_o), 6);
    bus(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0); check("R4", "byte read 1", int'(rdata_o), 16'h0001);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 1'b0); check("R3", "word read 2", int'(rdata_o), 16'h2345);
    @(negedge clk); check("R3", "read data held", int'(rdata_o), 16'h2345);
    bus(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0); check("R2", "byte read hi zero", int'(rdata_o), 16'h0067);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 1'b0); check("R4", "word read 4", int'(rdata_o), 16'h89AB);
    check("R8", "empty after drain", int'(empty_o), 1);
    model.delete();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 7; i++) put(1'b1, 16'(16'hA000 + i * 16'h0102));
    put(1'b0, 16'h00C1);
    check("R8", "count 15", int'(count_o), 15);
    bus(1'b0, 1'b1, 1'b0, 1'b1, 16'hDEAD, 1'b0);
    check("R6", "word write at 1 free dropped", int'(count_o), 15);
    check("R6", "ovf set", int'(ovf_o), 1);
    put(1'b0, 16'h00C2);
    check("R8", "full", int'(full_o), 1);
    bus(1'b0, 1'b1, 1'b0, 1'b0, 16'h00EE, 1'b0);
    check("R6", "byte write when full dropped", int'(count_o), 16);
    clear_flags();
    check("R9", "ovf cleared", int'(ovf_o), 0);
  endtask

  task automatic t_underflow();
    get("R4", 1'b0);
    for (int i = 0; i < 7; i++) get("R3", 1'b1);
    check("R8", "count 1", int'(count_o), 1);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 1'b0);
    check("R7", "word read at 1 dropped", int'(count_o), 1);
    check("R7", "udf set", int'(udf_o), 1);
    get("R7", 1'b0);
    bus(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
    check("R7", "byte read when empty dropped", int'(count_o), 0);
    // clear and a new error in the same cycle: error wins
    bus(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
    check("R9", "new udf beats clear", int'(udf_o), 1);
    clear_flags();
    check("R9", "udf cleared", int'(udf_o), 0);
  endtask

  task automatic t_illegal();
    put(1'b1, 16'h5AA5);
    bus(1'b1, 1'b1, 1'b0, 1'b0, 16'h0011, 1'b0);
    check("R5", "odd byte write count", int'(count_o), 2);
    check("R5", "acc_err set", int'(acc_err_o), 1);
    bus(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
    check("R5", "odd byte read count", int'(count_o), 2);
    bus(1'b1, 1'b1, 1'b0, 1'b1, 16'h2222, 1'b0);
    check("R5", "odd word write count", int'(count_o), 2);
    clear_flags();
    check("R9", "acc_err cleared", int'(acc_err_o), 0);
    bus(1'b0, 1'b1, 1'b1, 1'b1, 16'h3333, 1'b0);
    check("R5", "wr+rd count", int'(count_o), 2);
    check("R5", "wr+rd acc_err", int'(acc_err_o), 1);
    get("R5", 1'b1);
    clear_flags();
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 20; k++) begin
      put(1'b1, 16'(k * 16'h1311 + 16'h0102));
      put(1'b0, 16'(k * 16'h0007 + 16'h0030));
      get("R11", 1'b0);
      get("R11", 1'b1);
    end
    check("R11", "empty after wrap run", int'(empty_o), 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_mixed();
    t_overflow();
    t_underflow();
    t_illegal();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule